// File: doc/BRIEF.md
# Wide Register Write Collector

This block merges four 32-bit host writes into one atomic update of a 128-bit control register. The host bus carries a write strobe, a dword address and a data word. The two low address bits pick the dword within a wide register, and the upper bits pick the register. Dwords 0 to 2 are parked in a holding store, together with a tag naming the register they belong to. The register bank is left untouched until the top dword (select 3) arrives.

A write to the top dword always produces a single-cycle commit of the whole 128-bit value to the register bank. If the held dwords do not fully cover the low 96 bits for that same register, those bits are sent as zero rather than stale data. While partial data is pending for one register, low-dword writes aimed at another register are dropped. Every commit empties the store.

Top module: `wreg_collector`

## Requirements
- R1: A write with select 0, 1 or 2 is stored when the collector is empty or already tagged with the same register index. It causes no commit.
- R2: A write with select 3 produces exactly one cycle of `cmt_valid`, in the cycle after the write is sampled. Consecutive top writes give one pulse each.
- R3: A commit places the top-dword data in bits 127:96. When all three low dwords are held for the committed register, bits 95:0 hold them, with dword n in bits 32n+31:32n.
- R4: When the held dwords do not cover all of dwords 0 to 2 of the committed register, commit bits 95:0 are zero. This includes the case where the held data belongs to a different register.
- R5: A low-dword write to a register other than the tagged one, while any dword is held, is discarded. The held data and tag stay unchanged.
- R6: A repeated write to a dword already held for the tagged register replaces the held value.
- R7: After every commit the collector is empty, so the next low-dword write to any register is accepted.
- R8: Reset (`rst_n` low, asynchronous) empties the collector and holds `cmt_valid` low. Data held before reset is never committed.
- R9: `wr_addr[1:0]` is the dword select. `wr_addr[IDX_W+1:2]` is the register index, and it appears on `cmt_idx` with the commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wr_en | input | 1 | Host write strobe, one dword per cycle |
| wr_addr | input | IDX_W+2 | Register index (upper bits) and dword select (low two bits) |
| wr_data | input | DW | Host write data |
| cmt_valid | output | 1 | One-cycle commit strobe to the register bank |
| cmt_idx | output | IDX_W | Register index being committed |
| cmt_data | output | 4*DW | Full 128-bit value being committed |

## Verification
The assertions assume that `wr_addr` and `wr_data` are known whenever `wr_en` is high. They also assume at most one host dword arrives per cycle, and that reset is released away from the clock edge. The stimulus drives all inputs on the falling edge only, and holds the strobe low with a junk address between bursts. It asserts reset only when no commit is still expected. Register indices are drawn from a small range during the pseudo-random phase, so that tag collisions and discards happen often.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
  localparam int SEL_W   = 2;
  localparam int NUM_DW  = 4;
  localparam int NUM_LOW = NUM_DW - 1;

  typedef enum logic [SEL_W-1:0] {
    DSEL_0   = 2'd0,
    DSEL_1   = 2'd1,
    DSEL_2   = 2'd2,
    DSEL_TOP = 2'd3
  } dsel_e;
endpackage

// File: rtl/wrc_addr_split.sv
module wrc_addr_split #(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W+1:0]    addr,
  output logic [IDX_W-1:0]    idx,
  output wrc_pkg::dsel_e      sel,
  output logic                is_top
);
  // R9: low two bits select the dword, the rest name the register
  assign sel    = wrc_pkg::dsel_e'(addr[1:0]);
  assign idx    = addr[IDX_W+1:2];
  assign is_top = (sel == wrc_pkg::DSEL_TOP);
endmodule

// File: rtl/wrc_hold_store.sv
module wrc_hold_store #(
  parameter int IDX_W = 4,
  parameter int DW    = 32,
  localparam int NLOW = wrc_pkg::NUM_LOW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 is_top,
  input  wrc_pkg::dsel_e       sel,
  input  logic [IDX_W-1:0]     idx,
  input  logic [DW-1:0]        data,
  output logic [NLOW-1:0]      valid_q,
  output logic [IDX_W-1:0]     tag_q,
  output logic [NLOW*DW-1:0]   low_data,
  output logic                 full_match
);
  logic              any_held;
  logic              same_tag;
  logic              accept_low;
  logic              clear_all;
  logic [NLOW-1:0]   slot_hit;
  logic [NLOW-1:0]   valid_d;
  logic [IDX_W-1:0]  tag_d;

  assign any_held   = |valid_q;
  assign same_tag   = (tag_q == idx);
  assign accept_low = wr_en && !is_top && (!any_held || same_tag);
  assign clear_all  = wr_en && is_top;
  assign full_match = (&valid_q) && same_tag;

  generate
    for (genvar g = 0; g < NLOW; g++) begin : g_slot
      logic [DW-1:0] slot_q;

      assign slot_hit[g] = accept_low && (sel == wrc_pkg::dsel_e'(g));

      always_comb begin
        if (clear_all) valid_d[g] = 1'b0;
        else           valid_d[g] = valid_q[g] | slot_hit[g];
      end

      // data slot: clock enable only, no reset needed
      always_ff @(posedge clk) begin
        if (slot_hit[g]) slot_q <= data;
      end

      assign low_data[g*DW +: DW] = slot_q;
    end
  endgenerate

  always_comb begin
    tag_d = tag_q;
    if (accept_low) tag_d = idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      tag_q   <= '0;
    end else begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
    end
  end
endmodule

// File: rtl/wrc_commit_stage.sv
module wrc_commit_stage #(
  parameter int IDX_W = 4,
  parameter int DW    = 32,
  localparam int NLOW = wrc_pkg::NUM_LOW,
  localparam int WW   = wrc_pkg::NUM_DW * DW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic [IDX_W-1:0]    idx,
  input  logic [DW-1:0]       top_data,
  input  logic [NLOW*DW-1:0]  low_data,
  input  logic                full_match,
  output logic                cmt_valid,
  output logic [IDX_W-1:0]    cmt_idx,
  output logic [WW-1:0]       cmt_data
);
  logic [NLOW*DW-1:0] low_sel;
  logic [WW-1:0]      data_d;

  // zero-fill unless the store fully covers this register
  always_comb begin
    low_sel = full_match ? low_data : '0;
    data_d  = {top_data, low_sel};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmt_valid <= 1'b0;
    else        cmt_valid <= fire;
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      cmt_idx  <= idx;
      cmt_data <= data_d;
    end
  end
endmodule

// File: rtl/wreg_collector.sv
module wreg_collector #(
  parameter int IDX_W = 4,
  parameter int DW    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W+1:0]     wr_addr,
  input  logic [DW-1:0]        wr_data,
  output logic                 cmt_valid,
  output logic [IDX_W-1:0]     cmt_idx,
  output logic [4*DW-1:0]      cmt_data
);
  localparam int NLOW = wrc_pkg::NUM_LOW;

  logic [IDX_W-1:0]    wr_idx;
  wrc_pkg::dsel_e      wr_sel;
  logic                wr_is_top;
  logic [NLOW-1:0]     held_valid;
  logic [IDX_W-1:0]    held_tag;
  logic [NLOW*DW-1:0]  held_low;
  logic                held_full;

  wrc_addr_split #(.IDX_W(IDX_W)) u_split (
    .addr   (wr_addr),
    .idx    (wr_idx),
    .sel    (wr_sel),
    .is_top (wr_is_top)
  );

  wrc_hold_store #(.IDX_W(IDX_W), .DW(DW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .is_top     (wr_is_top),
    .sel        (wr_sel),
    .idx        (wr_idx),
    .data       (wr_data),
    .valid_q    (held_valid),
    .tag_q      (held_tag),
    .low_data   (held_low),
    .full_match (held_full)
  );

  wrc_commit_stage #(.IDX_W(IDX_W), .DW(DW)) u_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (wr_en && wr_is_top),
    .idx        (wr_idx),
    .top_data   (wr_data),
    .low_data   (held_low),
    .full_match (held_full),
    .cmt_valid  (cmt_valid),
    .cmt_idx    (cmt_idx),
    .cmt_data   (cmt_data)
  );
endmodule

// File: rtl/wrc_checker.sv
module wrc_checker #(
  parameter int IDX_W = 4,
  parameter int DW    = 32,
  localparam int NLOW = wrc_pkg::NUM_LOW
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [IDX_W+1:0]    wr_addr,
  input logic [DW-1:0]       wr_data,
  input logic                cmt_valid,
  input logic [IDX_W-1:0]    cmt_idx,
  input logic [4*DW-1:0]     cmt_data,
  input logic [NLOW-1:0]     valid_q,
  input logic [IDX_W-1:0]    tag_q,
  input logic [NLOW*DW-1:0]  low_data,
  input logic                full_match
);
  logic top_wr;
  logic low_wr;
  assign top_wr = wr_en && (wr_addr[1:0] == 2'd3);
  assign low_wr = wr_en && (wr_addr[1:0] != 2'd3);

  assert_no_commit_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    low_wr |=> !cmt_valid);

  assert_commit_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    top_wr |=> cmt_valid);

  assert_commit_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> $past(top_wr));

  assert_top_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> (cmt_data[4*DW-1:3*DW] == $past(wr_data)));

  assert_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && !$past(full_match)) |-> (cmt_data[3*DW-1:0] == '0));

  assert_discard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (low_wr && (valid_q != '0) && (tag_q != wr_addr[IDX_W+1:2]))
      |=> ($stable(valid_q) && $stable(tag_q) && $stable(low_data)));

  assert_empty_after_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> (valid_q == '0));

  assert_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> (cmt_idx == $past(wr_addr[IDX_W+1:2])));
endmodule

bind wreg_collector wrc_checker #(.IDX_W(IDX_W), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .cmt_valid  (cmt_valid),
  .cmt_idx    (cmt_idx),
  .cmt_data   (cmt_data),
  .valid_q    (held_valid),
  .tag_q      (held_tag),
  .low_data   (held_low),
  .full_match (held_full)
);

// File: tb/sim_wreg_collector.sv
module sim_wreg_collector;
  localparam int IDX_W = 4;
  localparam int DW    = 32;
  localparam int AW    = IDX_W + 2;
  localparam int WW    = 4 * DW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [AW-1:0]    wr_addr = '0;
  logic [DW-1:0]    wr_data = '0;
  logic             cmt_valid;
  logic [IDX_W-1:0] cmt_idx;
  logic [WW-1:0]    cmt_data;

  always #2 clk = ~clk;

  wreg_collector #(.IDX_W(IDX_W), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmt_valid(cmt_valid), .cmt_idx(cmt_idx),
    .cmt_data(cmt_data)
  );

  typedef struct {
    logic [IDX_W-1:0] idx;
    logic [WW-1:0]    data;
    int               due;
    string            req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  logic [DW-1:0]    m_low [3];
  logic [2:0]       m_v;
  logic [IDX_W-1:0] m_tag;
  logic [31:0]      lfsr = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic model_clear();
    m_v   = '0;
    m_tag = '0;
  endtask

  // driver: one host dword per call, model updated, expected commit queued
  task automatic wr(input int idx, input int sel, input logic [DW-1:0] d, input string req);
    exp_t e;
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = {idx[IDX_W-1:0], sel[1:0]};
    wr_data = d;
    if (sel == 3) begin
      e.idx  = idx[IDX_W-1:0];
      e.due  = cyc + 1;
      e.req  = req;
      if (m_v == 3'b111 && m_tag == idx[IDX_W-1:0])
        e.data = {d, m_low[2], m_low[1], m_low[0]};
      else
        e.data = {d, {(3*DW){1'b0}}};
      q.push_back(e);
      m_v = '0;
    end else if (m_v == 3'b000 || m_tag == idx[IDX_W-1:0]) begin
      m_low[sel] = d;
      m_v[sel]   = 1'b1;
      m_tag      = idx[IDX_W-1:0];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en   = 1'b0;
      wr_addr = AW'(6'h2b + i);
      wr_data = 32'hDEAD_0000 + DW'(i);
    end
  endtask

  task automatic drained(input string req);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL %s: pending commits actual=%0d expected=0", req, q.size());
    end
  endtask

  function automatic logic [DW-1:0] dv(input int r, input int s);
    return 32'hC0DE_0000 ^ (DW'(r) << 8) ^ DW'(s) ^ 32'h0101_0000 * DW'(r + s);
  endfunction

  // monitor: pops the scoreboard when the design produces a commit
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        if (cmt_valid) begin
          if (q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R1: unexpected commit idx=%0d data=%h expected=none", cmt_idx, cmt_data);
          end else begin
            e = q.pop_front();
            checks++;
            if (e.due != cyc || cmt_idx != e.idx || cmt_data != e.data) begin
              errors++;
              $display("FAIL %s: cycle=%0d idx=%0d data=%h expected cycle=%0d idx=%0d data=%h",
                       e.req, cyc, cmt_idx, cmt_data, e.due, e.idx, e.data);
            end
          end
        end else begin
          while (q.size() > 0 && q[0].due <= cyc) begin
            e = q.pop_front();
            checks++;
            errors++;
            $display("FAIL %s: missing commit cmt_valid=0 expected idx=%0d data=%h",
                     e.req, e.idx, e.data);
          end
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    checks++;
    if (cmt_valid !== 1'b0) begin
      errors++;
      $display("FAIL R8: cmt_valid after reset actual=%b expected=0", cmt_valid);
    end

    // R3: full four-dword write
    wr(5, 0, dv(5, 0), "R3"); wr(5, 1, dv(5, 1), "R3");
    wr(5, 2, dv(5, 2), "R3"); wr(5, 3, dv(5, 3), "R3");
    idle(3);

    // R9: out-of-order low dwords, highest index
    wr(15, 2, dv(15, 2), "R9"); wr(15, 0, dv(15, 0), "R9");
    wr(15, 1, dv(15, 1), "R9"); wr(15, 3, dv(15, 3), "R9");
    idle(2);

    // R4: top alone, then partial cover
    wr(2, 3, dv(2, 3), "R4");
    idle(2);
    wr(7, 0, dv(7, 0), "R4"); wr(7, 2, dv(7, 2), "R4"); wr(7, 3, dv(7, 3), "R4");
    idle(2);

    // R5: a foreign low write is discarded, held data survives
    wr(3, 0, dv(3, 0), "R5"); wr(3, 1, dv(3, 1), "R5"); wr(3, 2, dv(3, 2), "R5");
    wr(4, 1, 32'hBAD0_BAD0, "R5"); wr(9, 0, 32'hBAD1_BAD1, "R5");
    wr(3, 3, dv(3, 3), "R5");
    idle(2);

    // R4 + R7: top of another register commits zero-filled and empties the store
    wr(1, 0, dv(1, 0), "R4"); wr(1, 1, dv(1, 1), "R4"); wr(1, 2, dv(1, 2), "R4");
    wr(6, 3, dv(6, 3), "R4");
    wr(9, 0, dv(9, 0), "R7"); wr(9, 1, dv(9, 1), "R7"); wr(9, 2, dv(9, 2), "R7");
    wr(9, 3, dv(9, 3), "R7");
    idle(2);

    // R6: overwrite of a held dword
    wr(8, 0, 32'h1111_1111, "R6"); wr(8, 0, 32'h2222_2222, "R6");
    wr(8, 1, dv(8, 1), "R6"); wr(8, 2, dv(8, 2), "R6");
    wr(8, 2, 32'h3333_3333, "R6"); wr(8, 3, dv(8, 3), "R6");
    idle(2);

    // R2: back-to-back top writes, one pulse each
    wr(10, 3, dv(10, 3), "R2"); wr(11, 3, dv(11, 3), "R2"); wr(12, 3, dv(12, 3), "R2");
    idle(3);
    drained("R2");

    // R8: reset while holding data, then top write commits zero-filled
    wr(4, 0, dv(4, 0), "R8"); wr(4, 1, dv(4, 1), "R8"); wr(4, 2, dv(4, 2), "R8");
    idle(2);
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    rst_n = 1'b1;
    wr(4, 3, dv(4, 3), "R8");
    idle(2);

    // R1: pseudo-random traffic over a small index range
    for (int k = 0; k < 400; k++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      if (lfsr[7:5] == 3'd0) idle(1);
      else wr(int'(lfsr[9:8]), int'(lfsr[1:0]), lfsr, "R1");
    end
    idle(4);
    drained("R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule